// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank, four-bank synchronous DRAM from power-on to a usable state by driving its command, address and bank pins through a fixed bring-up order. After reset it lets the device settle for a stabilization pause of at least 100 µs. The pause is counted in clock cycles from a clock-frequency parameter. Next it closes every bank with one precharge-all. Once the row-precharge time has passed, it programs the mode register and runs a configurable burst of auto-refresh cycles. A parameter sets which of those two phases comes first. A single flag then tells the memory controller that the device may be used.

During the pause no command pin changes. Clock enable and data mask stay high so that the data bus remains high-impedance until the precharge-all goes out. Each command lasts exactly one clock, and the pins carry a no-operation command in every other cycle. All timing values are elaboration parameters. The only run-time data input is the mode-register value, which is captured on the cycle the mode-register-set command is issued. Control pins are plain levels, with no handshake.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and for PAUSE_US*CLK_MHZ cycles after it is released, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), addr = 0, ba = 0, cke = 1, dqm = 1 and init_done = 0.
- R2: The first command is precharge-all (4'b0010), with address bit 10 set and all other address and bank bits 0. It appears PAUSE_US*CLK_MHZ cycles after reset is released.
- R3: Mode-register-set (4'b0000) drives mode_value[ADDR_W-1:0] on addr and mode_value[ADDR_W+BA_W-1:ADDR_W] on ba. When MRS_FIRST=1 it follows the precharge-all by exactly T_RP cycles.
- R4: After mode-register-set, exactly T_RSC cycles (T_RSC >= 2) pass before the next command, or before init_done rises, and all of them are NOP.
- R5: REF_COUNT (>= 2) auto-refresh commands (4'b0001) are issued with addr = 0 and ba = 0. Each is followed by T_RC cycles before the next command or before init_done rises.
- R6: With MRS_FIRST=1 the order is mode-register-set, then the refresh burst. With MRS_FIRST=0 the refresh burst begins T_RP cycles after the precharge-all, and mode-register-set comes after the burst.
- R7: cke stays 1 at all times. dqm is 1 up to and including the precharge-all cycle, and 0 from the next cycle on.
- R8: Every command lasts one cycle. All other cycles carry NOP with addr = 0 and ba = 0.
- R9: init_done rises when the final wait of the sequence ends, and stays 1 with NOP on the pins until reset.
- R10: A synchronous reset asserted mid-sequence returns all outputs to the R1 state at the next clock edge, and the whole sequence then restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_value | input | ADDR_W+BA_W | Value written to the mode register (bank bits on top) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| addr | output | ADDR_W | Address pins |
| ba | output | BA_W | Bank select pins |
| init_done | output | 1 | Memory initialized |

## Verification
Every output is registered, so with P = PAUSE_US*CLK_MHZ, cycle n counts the n-th clock edge after reset release, starting at 0. The bench computes for each cycle n which command, address, mask and done level is due. The precharge-all falls on cycle P. Each later command is placed by adding T_RP, T_RSC or T_RC to the cycle of the command before it, in the order MRS_FIRST selects. init_done is due on the cycle the last wait ends. The bench samples every pin on the falling edge after each clock edge and compares it with that cycle's expected value, for both phase orders at once. It also checks that a reset asserted mid-sequence shows its effect on the pins after exactly one edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Pin order {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP = 4'b0111;
  localparam sdram_cmd_t CMD_PRE = 4'b0010;
  localparam sdram_cmd_t CMD_REF = 4'b0001;
  localparam sdram_cmd_t CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_RSC,
    ST_REF,
    ST_WAIT_RC,
    ST_DONE
  } init_state_t;

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counter shared by every wait phase. It comes out of reset loaded
// with the pause length and is reloaded by each command state.
module sdram_init_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= CW'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // Each idle cycle removes exactly one from the remaining wait (R4, R5).
  assert_timer_counts_down_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

  // A zero count stays at zero until the next reload.
  assert_timer_holds_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);

endmodule

// File: rtl/sdram_init_drive.sv
// Registers the pin image for the current sequencer state.
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  init_state_t            st,
  input  logic [ADDR_W+BA_W-1:0] mode_value,
  output sdram_cmd_t             cmd,
  output logic [ADDR_W-1:0]      addr,
  output logic [BA_W-1:0]        ba,
  output logic                   dqm,
  output logic                   done
);

  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = {{(ADDR_W-11){1'b0}}, 1'b1, 10'b0};

  sdram_cmd_t          cmd_d;
  logic [ADDR_W-1:0]   addr_d;
  logic [BA_W-1:0]     ba_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    case (st)
      ST_PRE: begin
        cmd_d  = CMD_PRE;
        addr_d = PRE_ALL_ADDR;
      end
      ST_MRS: begin
        cmd_d  = CMD_MRS;
        addr_d = mode_value[ADDR_W-1:0];
        ba_d   = mode_value[ADDR_W+BA_W-1:ADDR_W];
      end
      ST_REF:  cmd_d = CMD_REF;
      default: cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      dqm  <= 1'b1;
      done <= 1'b0;
    end else begin
      cmd  <= cmd_d;
      addr <= addr_d;
      ba   <= ba_d;
      done <= (st == ST_DONE);
      if (cmd == CMD_PRE) dqm <= 1'b0;
    end
  end

  assert_one_cycle_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_dqm_stays_low_R7: assert property (@(posedge clk) disable iff (rst)
    !dqm |=> !dqm);

  assert_dqm_high_at_pre_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> dqm);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 100,
  parameter int T_RP      = 3,
  parameter int T_RSC     = 2,
  parameter int T_RC      = 9,
  parameter int REF_COUNT = 2,
  parameter bit MRS_FIRST = 1'b1,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W+BA_W-1:0] mode_value,
  output logic                   cs_n,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   cke,
  output logic                   dqm,
  output logic [ADDR_W-1:0]      addr,
  output logic [BA_W-1:0]        ba,
  output logic                   init_done
);

  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int MAX_T1    = (T_RP > T_RSC) ? T_RP : T_RSC;
  localparam int MAX_T2    = (MAX_T1 > T_RC) ? MAX_T1 : T_RC;
  localparam int MAX_T     = (PAUSE_CYC > MAX_T2) ? PAUSE_CYC : MAX_T2;
  localparam int CW        = $clog2(MAX_T + 1);
  localparam int RW        = $clog2(REF_COUNT + 1);

  init_state_t    st_q, st_d;
  logic [RW-1:0]  ref_left_q;
  logic           tmr_load;
  logic [CW-1:0]  tmr_val;
  logic           tmr_zero;
  sdram_cmd_t     pin_cmd;

  sdram_init_timer #(.CW(CW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Command states last one cycle and load the following gap minus two,
  // so that consecutive commands sit exactly T cycles apart.
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_PAUSE:    if (tmr_zero) st_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RP - 2);
        st_d     = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (tmr_zero) st_d = MRS_FIRST ? ST_MRS : ST_REF;
      ST_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RSC - 2);
        st_d     = ST_WAIT_RSC;
      end
      ST_WAIT_RSC: if (tmr_zero) st_d = MRS_FIRST ? ST_REF : ST_DONE;
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RC - 2);
        st_d     = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (tmr_zero) begin
          if (ref_left_q != '0) st_d = ST_REF;
          else                  st_d = MRS_FIRST ? ST_DONE : ST_MRS;
        end
      end
      ST_DONE:     st_d = ST_DONE;
      default:     st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_PAUSE;
      ref_left_q <= RW'(REF_COUNT);
    end else begin
      st_q <= st_d;
      if (st_q == ST_REF) ref_left_q <= ref_left_q - 1'b1;
    end
  end

  sdram_init_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .st         (st_q),
    .mode_value (mode_value),
    .cmd        (pin_cmd),
    .addr       (addr),
    .ba         (ba),
    .dqm        (dqm),
    .done       (init_done)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pin_cmd;
  assign cke = 1'b1;

  // The refresh burst never issues more than REF_COUNT commands.
  assert_ref_budget_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REF) |-> (ref_left_q != '0));

  // Once initialized, the pins stay quiet.
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (pin_cmd == CMD_NOP && addr == '0 && ba == '0));

  // Precharge-all always carries address bit 10.
  assert_pre_all_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd == CMD_PRE) |-> (addr[10] && ba == '0));

  // Leaving the pause means the precharge-all is the next command on the pins.
  assert_first_cmd_pre_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PRE) |=> (pin_cmd == CMD_PRE));

endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 1;
  localparam int PAUSE_US   = 20;
  localparam int T_RP       = 3;
  localparam int T_RSC      = 2;
  localparam int T_RC       = 4;
  localparam int REF_COUNT  = 3;
  localparam int ADDR_W     = 13;
  localparam int BA_W       = 2;
  localparam int P          = PAUSE_US * CLK_MHZ;
  localparam int LAST       = P + T_RP + T_RSC + REF_COUNT * T_RC + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W+BA_W-1:0] mode_value = '0;

  logic [3:0] c0, c1;
  logic k0, k1, m0, m1, d0, d1;
  logic [ADDR_W-1:0] a0, a1;
  logic [BA_W-1:0] b0, b1;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RSC(T_RSC),
    .T_RC(T_RC), .REF_COUNT(REF_COUNT), .MRS_FIRST(1'b1), .ADDR_W(ADDR_W), .BA_W(BA_W)) u0 (
    .clk(clk), .rst(rst), .mode_value(mode_value),
    .cs_n(c0[3]), .ras_n(c0[2]), .cas_n(c0[1]), .we_n(c0[0]),
    .cke(k0), .dqm(m0), .addr(a0), .ba(b0), .init_done(d0));

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RSC(T_RSC),
    .T_RC(T_RC), .REF_COUNT(REF_COUNT), .MRS_FIRST(1'b0), .ADDR_W(ADDR_W), .BA_W(BA_W)) u1 (
    .clk(clk), .rst(rst), .mode_value(mode_value),
    .cs_n(c1[3]), .ras_n(c1[2]), .cas_n(c1[1]), .we_n(c1[0]),
    .cke(k1), .dqm(m1), .addr(a1), .ba(b1), .init_done(d1));

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(bit ok, string tag, string what, int n, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, n, act, exp);
    end
  endtask

  // Expected-schedule helpers, derived from the requirement timings.
  function automatic int mrs_at(bit mf);
    return mf ? (P + T_RP) : (P + T_RP + REF_COUNT * T_RC);
  endfunction

  function automatic int ref_at(bit mf, int k);
    return mf ? (P + T_RP + T_RSC + k * T_RC) : (P + T_RP + k * T_RC);
  endfunction

  function automatic int done_at(bit mf);
    return mf ? (ref_at(1'b1, REF_COUNT - 1) + T_RC) : (mrs_at(1'b0) + T_RSC);
  endfunction

  function automatic logic [3:0] exp_cmd(bit mf, int n);
    if (n == P) return 4'b0010;
    if (n == mrs_at(mf)) return 4'b0000;
    for (int k = 0; k < REF_COUNT; k++)
      if (n == ref_at(mf, k)) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic string cmd_tag(bit mf, int n);
    logic [3:0] e;
    e = exp_cmd(mf, n);
    if (e == 4'b0010) return "R2";
    if (e == 4'b0000) return mf ? "R3" : "R6";
    if (e == 4'b0001) return "R5";
    if (n > mrs_at(mf) && n < mrs_at(mf) + T_RSC) return "R4";
    if (n < P) return "R1";
    return "R8";
  endfunction

  task automatic check_inst(bit mf, int n, logic [3:0] c, logic [ADDR_W-1:0] a,
                            logic [BA_W-1:0] b, logic k, logic m, logic d);
    logic [3:0] ec;
    logic [ADDR_W-1:0] ea;
    logic [BA_W-1:0] eb;
    ec = exp_cmd(mf, n);
    ea = '0;
    eb = '0;
    if (ec == 4'b0010) ea = 13'h0400;
    if (ec == 4'b0000) begin
      ea = mode_value[ADDR_W-1:0];
      eb = mode_value[ADDR_W+BA_W-1:ADDR_W];
    end
    check(c == ec, cmd_tag(mf, n), mf ? "u0 cmd" : "u1 cmd", n, c, ec);
    check({b, a} == {eb, ea}, (ec == 4'b0000) ? "R3" : ((ec == 4'b0010) ? "R2" : "R8"),
          mf ? "u0 ba/addr" : "u1 ba/addr", n, {b, a}, {eb, ea});
    check(k == 1'b1, "R7", mf ? "u0 cke" : "u1 cke", n, k, 1);
    check(m == (n <= P), "R7", mf ? "u0 dqm" : "u1 dqm", n, m, (n <= P));
    check(d == (n >= done_at(mf)), "R9", mf ? "u0 init_done" : "u1 init_done", n, d,
          (n >= done_at(mf)));
  endtask

  task automatic check_reset_state(string tag);
    check(c0 == 4'b0111 && c1 == 4'b0111, tag, "cmd in reset", -1, {c0, c1}, 8'h77);
    check(a0 == '0 && a1 == '0 && b0 == '0 && b1 == '0, tag, "addr/ba in reset", -1,
          {a0, a1}, 0);
    check(m0 && m1 && k0 && k1, tag, "cke/dqm in reset", -1, {k0, k1, m0, m1}, 4'hf);
    check(!d0 && !d1, tag, "init_done in reset", -1, {d0, d1}, 0);
  endtask

  // Cycle n is sampled at the falling edge after the n-th rising edge since release.
  task automatic run_cycles(int upto);
    for (int n = 0; n <= upto; n++) begin
      @(negedge clk);
      check_inst(1'b1, n, c0, a0, b0, k0, m0, d0);
      check_inst(1'b0, n, c1, a1, b1, k1, m1, d1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    mode_value = 15'h0237;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;
    // R6: u0 runs MRS before refresh, u1 after.
    run_cycles(LAST);

    // R10: reset in the middle of the refresh/MRS phases, then full restart.
    mode_value = 15'h6a5c;
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;
    run_cycles(P + T_RP + 5);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("R10");
    rst = 1'b0;
    run_cycles(LAST);

    // Third pass with a different mode value and an all-ones bank field.
    mode_value = 15'h7fc3;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R10");
    rst = 1'b0;
    run_cycles(LAST);

    report();
  end

endmodule